// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache placed between a processor port and a line-wide memory port. Each set holds two ways. Each way has its own valid flag, dirty flag, tag and data line, and each set has one recency bit that selects the replacement way. Stores hit in place and mark the line dirty. A store miss allocates the line: it fetches the line from memory and merges the store word into it.

The processor presents one request per cycle. Acceptance is reported in the same cycle. The result comes back as an optional word one cycle after the hit, or one cycle after the fill that completes a miss. A miss whose victim is dirty is rejected, and the victim is written back and invalidated. The processor retries the request, and the retry then allocates a line. Outstanding misses wait in a small queue. Each queue entry records the way picked for it, so its fill lands in that way. Memory serves line reads in order.

Addresses are word addresses. Bits [OFFW-1:0] select the word in the line, the next SETW bits select the set, and the remaining high bits are the tag. With the defaults this means 4 words per line, 8 sets and an 11-bit tag.

Top module: `cache2w`

## Requirements
- R1: After reset every way is invalid and every recency bit is 0. No response and no memory request is presented, so the first access to any address misses.
- R2: An accepted request that hits is accepted in its own cycle, and resp_valid_o is high in the next cycle. A load returns the addressed word. A store writes its word into the line, marks that way dirty, and returns the stored word.
- R3: The victim on a miss is the way whose index equals the set's recency bit. A hit in way i sets that bit to 1-i. Any looked-up request that misses inverts the bit, whether the request is accepted or not.
- R4: A miss whose victim is valid and dirty is rejected. If mem_req_ready_i is high in that cycle, the victim is invalidated and a write (mem_req_we_o=1) of its line is issued at the address {victim tag, set, word 0}.
- R5: A miss whose victim is clean or invalid is accepted only when mem_req_ready_i is high and the miss queue has room. It then issues a line read (mem_req_we_o=0) at {tag, set, word 0}, for loads and stores alike.
- R6: When the line for a load miss arrives and is taken, it is written into the way recorded for that miss, marked valid and clean. In the next cycle resp_valid_o is high with the addressed word.
- R7: When the line for a store miss is taken, the store word is merged into it at its offset and the way is marked valid and dirty. The response in the next cycle carries the store word.
- R8: A request whose set matches any queued miss is rejected. It issues nothing and changes no state, its recency bit included.
- R9: A memory response is taken (mem_resp_ready_o high) only when a miss is queued, mem_resp_valid_i is high, and the request port produces no hit, write-back or line read in that cycle. Fills complete in the order their misses were issued.
- R10: A lookup never matches in both ways of a set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Processor request present |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Store word |
| req_accepted_o | output | 1 | Request accepted this cycle |
| resp_valid_o | output | 1 | Response word valid |
| resp_data_o | output | DW | Response word |
| mem_req_valid_o | output | 1 | Memory request present |
| mem_req_ready_i | input | 1 | Memory request queue has room |
| mem_req_we_o | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr_o | output | AW | Line address, word offset zero |
| mem_req_line_o | output | WORDS*DW | Write-back line |
| mem_resp_valid_i | input | 1 | Read line available |
| mem_resp_line_i | input | WORDS*DW | Read line data |
| mem_resp_ready_o | output | 1 | Read line taken this cycle |

## Verification
A wrong recency bit does not show at once. It shows at the next miss to that set, where the write-back or read address carries the wrong tag, or where a clean line is evicted in place of another. A lost dirty flag or a fill into the wrong way shows later still: either a write-back is missing, or a stale word comes back on a later hit. The bench therefore predicts every acceptance, every memory request, every fill handshake and every response word in each cycle. Its traffic is crowded onto a few tags and sets, so that state errors reach the ports within a few tens of cycles.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int NUM_WAYS = 2;
  typedef enum logic [1:0] {ACT_IDLE, ACT_HIT, ACT_EVICT, ACT_FETCH} front_act_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SETS  = 8,
  parameter int TAGW  = 11,
  parameter int DW    = 16,
  parameter int WORDS = 4,
  localparam int SETW = $clog2(SETS),
  localparam int OFFW = $clog2(WORDS),
  localparam int LW   = WORDS * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SETW-1:0] rd_set_i,
  input  logic [TAGW-1:0] rd_tag_i,
  output logic            hit_o,
  output logic            valid_o,
  output logic            dirty_o,
  output logic [TAGW-1:0] tag_o,
  output logic [LW-1:0]   line_o,
  input  logic            wr_en_i,
  input  logic [OFFW-1:0] wr_off_i,
  input  logic [DW-1:0]   wr_word_i,
  input  logic            inv_en_i,
  input  logic            fill_en_i,
  input  logic [SETW-1:0] fill_set_i,
  input  logic [TAGW-1:0] fill_tag_i,
  input  logic [LW-1:0]   fill_line_i,
  input  logic            fill_dirty_i
);
  logic [SETS-1:0] valid_q, dirty_q;
  logic [TAGW-1:0] tag_q  [SETS];
  logic [LW-1:0]   data_q [SETS];

  assign valid_o = valid_q[rd_set_i];
  assign dirty_o = dirty_q[rd_set_i];
  assign tag_o   = tag_q[rd_set_i];
  assign line_o  = data_q[rd_set_i];
  assign hit_o   = valid_o && (tag_o == rd_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en_i) begin
        valid_q[fill_set_i] <= 1'b1;
        dirty_q[fill_set_i] <= fill_dirty_i;
      end
      if (inv_en_i) begin
        valid_q[rd_set_i] <= 1'b0;
        dirty_q[rd_set_i] <= 1'b0;
      end
      if (wr_en_i) dirty_q[rd_set_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fill_set_i]  <= fill_tag_i;
      data_q[fill_set_i] <= fill_line_i;
    end
    if (wr_en_i) data_q[rd_set_i][wr_off_i*DW +: DW] <= wr_word_i;
  end

  // store hit must land on a resident line
  p_store_on_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> valid_o && !inv_en_i);
endmodule

// File: rtl/cache2w_missq.sv
module cache2w_missq #(
  parameter int DEPTH = 2,
  parameter int EW    = 32,
  parameter int SETW  = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [EW-1:0]   push_ent_i,
  input  logic            pop_i,
  output logic [EW-1:0]   head_o,
  output logic            nempty_o,
  output logic            full_o,
  input  logic [SETW-1:0] q_set_i,
  output logic            busy_o
);
  logic [EW-1:0]    ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    wptr_q, rptr_q;
  logic [DEPTH-1:0] match;

  assign head_o   = ent_q[rptr_q];
  assign nempty_o = vld_q[rptr_q];
  assign full_o   = vld_q[wptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign match[g] = vld_q[g] && (ent_q[g][SETW-1:0] == q_set_i);
  end
  assign busy_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_i) begin
        vld_q[wptr_q] <= 1'b1;
        wptr_q <= (wptr_q == PW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      end
      if (pop_i) begin
        vld_q[rptr_q] <= 1'b0;
        rptr_q <= (rptr_q == PW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) ent_q[wptr_q] <= push_ent_i;
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> nempty_o);
endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int WORDS      = 4,
  parameter int SETS       = 8,
  parameter int MISS_DEPTH = 2,
  localparam int OFFW = $clog2(WORDS),
  localparam int SETW = $clog2(SETS),
  localparam int TAGW = AW - SETW - OFFW,
  localparam int LW   = WORDS * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_accepted_o,
  output logic          resp_valid_o,
  output logic [DW-1:0] resp_data_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic          mem_req_we_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [LW-1:0] mem_req_line_o,
  input  logic          mem_resp_valid_i,
  input  logic [LW-1:0] mem_resp_line_i,
  output logic          mem_resp_ready_o
);
  typedef struct packed {
    logic            we;
    logic [DW-1:0]   wdata;
    logic [OFFW-1:0] off;
    logic [TAGW-1:0] tag;
    logic            way;
    logic [SETW-1:0] set;
  } miss_ent_t;
  localparam int EW = $bits(miss_ent_t);

  logic [SETW-1:0] r_set;
  logic [TAGW-1:0] r_tag;
  logic [OFFW-1:0] r_off;
  assign r_off = req_addr_i[OFFW-1:0];
  assign r_set = req_addr_i[OFFW +: SETW];
  assign r_tag = req_addr_i[AW-1 -: TAGW];

  logic [NUM_WAYS-1:0] w_hit, w_valid, w_dirty;
  logic [TAGW-1:0]     w_tag  [NUM_WAYS];
  logic [LW-1:0]       w_line [NUM_WAYS];

  logic [SETS-1:0] lru_q;
  logic            busy, q_full, q_nempty, look, hit_any, hit_way, vict, fill_go;
  front_act_e      act;
  miss_ent_t       head, push_ent;
  logic [LW-1:0]   fill_line;

  always_comb begin
    hit_any = |w_hit;
    hit_way = w_hit[1];
    vict    = lru_q[r_set];
    look    = req_valid_i && !busy;
    act     = ACT_IDLE;
    if (look) begin
      if (hit_any)                            act = ACT_HIT;
      else if (w_valid[vict] && w_dirty[vict]) act = mem_req_ready_i ? ACT_EVICT : ACT_IDLE;
      else if (mem_req_ready_i && !q_full)    act = ACT_FETCH;
    end
    fill_go = q_nempty && mem_resp_valid_i && (act == ACT_IDLE);
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    cache2w_way #(.SETS(SETS), .TAGW(TAGW), .DW(DW), .WORDS(WORDS)) u_way (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rd_set_i    (r_set),
      .rd_tag_i    (r_tag),
      .hit_o       (w_hit[g]),
      .valid_o     (w_valid[g]),
      .dirty_o     (w_dirty[g]),
      .tag_o       (w_tag[g]),
      .line_o      (w_line[g]),
      .wr_en_i     ((act == ACT_HIT) && req_we_i && (hit_way == 1'(g))),
      .wr_off_i    (r_off),
      .wr_word_i   (req_wdata_i),
      .inv_en_i    ((act == ACT_EVICT) && (vict == 1'(g))),
      .fill_en_i   (fill_go && (head.way == 1'(g))),
      .fill_set_i  (head.set),
      .fill_tag_i  (head.tag),
      .fill_line_i (fill_line),
      .fill_dirty_i(head.we)
    );
  end

  assign push_ent = '{we: req_we_i, wdata: req_wdata_i, off: r_off,
                      tag: r_tag, way: vict, set: r_set};

  cache2w_missq #(.DEPTH(MISS_DEPTH), .EW(EW), .SETW(SETW)) u_missq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (act == ACT_FETCH),
    .push_ent_i(push_ent),
    .pop_i     (fill_go),
    .head_o    (head),
    .nempty_o  (q_nempty),
    .full_o    (q_full),
    .q_set_i   (r_set),
    .busy_o    (busy)
  );

  always_comb begin
    fill_line = mem_resp_line_i;
    if (head.we) fill_line[head.off*DW +: DW] = head.wdata;
  end

  assign req_accepted_o   = (act == ACT_HIT) || (act == ACT_FETCH);
  assign mem_req_valid_o  = (act == ACT_EVICT) || (act == ACT_FETCH);
  assign mem_req_we_o     = (act == ACT_EVICT);
  assign mem_req_addr_o   = {((act == ACT_EVICT) ? w_tag[vict] : r_tag), r_set, OFFW'(0)};
  assign mem_req_line_o   = w_line[vict];
  assign mem_resp_ready_o = fill_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else if (look) lru_q[r_set] <= hit_any ? ~hit_way : ~lru_q[r_set];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_data_o  <= '0;
    end else begin
      resp_valid_o <= (act == ACT_HIT) || fill_go;
      if (act == ACT_HIT)
        resp_data_o <= req_we_i ? req_wdata_i : w_line[hit_way][r_off*DW +: DW];
      else if (fill_go)
        resp_data_o <= fill_line[head.off*DW +: DW];
    end
  end

  p_one_way_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot0(w_hit));
  p_lru_after_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    look && hit_any |=> lru_q[$past(r_set)] == !$past(hit_way));
  p_lru_after_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    look && !hit_any |=> lru_q[$past(r_set)] != $past(lru_q[r_set]));
  p_evict_rejects_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == ACT_EVICT |-> !req_accepted_o && mem_req_valid_o && mem_req_we_o);
  p_fill_resp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |=> resp_valid_o);
  p_busy_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && busy |-> !req_accepted_o && !mem_req_valid_o);
endmodule

// File: tb/cache2w_bench.sv
`timescale 1ns/1ps
module cache2w_bench;
  localparam int AW = 16, DW = 16, WORDS = 4, SETS = 8, DEPTH = 2;
  localparam int LW = WORDS * DW;
  localparam int TAGW = 11;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid, req_we, req_accepted, resp_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, resp_data;
  logic          mreq_valid, mreq_ready, mreq_we, mresp_valid, mresp_ready;
  logic [AW-1:0] mreq_addr;
  logic [LW-1:0] mreq_line, mresp_line;

  cache2w u_cache2w (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_accepted_o(req_accepted),
    .resp_valid_o(resp_valid), .resp_data_o(resp_data),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_we_o(mreq_we), .mem_req_addr_o(mreq_addr), .mem_req_line_o(mreq_line),
    .mem_resp_valid_i(mresp_valid), .mem_resp_line_i(mresp_line),
    .mem_resp_ready_o(mresp_ready)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference state
  typedef struct { int way; int set; logic [TAGW-1:0] tag; int off; bit we; logic [DW-1:0] wd; } mq_t;
  typedef struct { int due; logic [LW-1:0] line; } rd_t;
  bit              mv [2][SETS];
  bit              md [2][SETS];
  logic [TAGW-1:0] mt [2][SETS];
  logic [LW-1:0]   ml [2][SETS];
  bit              mlru [SETS];
  mq_t             mq [$];
  rd_t             rdq [$];
  logic [LW-1:0]   mem [int];
  bit              e_rv = 0;
  logic [DW-1:0]   e_rd = '0;

  function automatic logic [LW-1:0] get_line(int a);
    logic [LW-1:0] l;
    if (mem.exists(a)) return mem[a];
    for (int i = 0; i < WORDS; i++) l[i*DW +: DW] = DW'(a * 37 + i * 5 + 16'h1200);
    return l;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit hold = 0;
    req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    mreq_ready = 0; mresp_valid = 0; mresp_line = '0;
    for (int s = 0; s < SETS; s++) begin
      mlru[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[w][s] = 0; md[w][s] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: idle after reset
    chk(resp_valid == 1'b0, "R1 resp_valid after reset", 64'(resp_valid), 0);
    chk(mreq_valid == 1'b0, "R1 mem_req_valid after reset", 64'(mreq_valid), 0);
    chk(req_accepted == 1'b0, "R1 accepted while idle", 64'(req_accepted), 0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int s, of, vict, hw;
      logic [TAGW-1:0] tg;
      bit busy, look, h0, h1, hit, hit_go, evict, miss, pfill, pacc, n_rv;
      logic [DW-1:0] n_rd;
      logic [AW-1:0] paddr;
      @(negedge clk);
      if (!hold) begin
        int t, st;
        t  = (cyc < 1500) ? $urandom % 3 : $urandom % 6;
        st = (cyc % 500 < 250) ? $urandom % 2 : $urandom % SETS;
        req_valid = ($urandom % 4) != 0;
        req_we    = $urandom % 2;
        req_addr  = {TAGW'(t), 3'(st), 2'($urandom % 4)};
        req_wdata = DW'($urandom);
      end
      mreq_ready = (cyc < 1000) ? 1'b1 : (($urandom % 4) != 0);
      if (rdq.size() > 0 && rdq[0].due <= cyc && ($urandom % 5) != 0) begin
        mresp_valid = 1'b1; mresp_line = rdq[0].line;
      end else begin
        mresp_valid = 1'b0; mresp_line = '0;
      end
      #1;
      s  = int'(req_addr[4:2]);
      tg = req_addr[15:5];
      of = int'(req_addr[1:0]);
      busy = 0;
      foreach (mq[i]) if (mq[i].set == s) busy = 1;
      look = req_valid && !busy;
      h0 = mv[0][s] && (mt[0][s] == tg);
      h1 = mv[1][s] && (mt[1][s] == tg);
      hit = h0 || h1;
      hw = h1 ? 1 : 0;
      vict = mlru[s] ? 1 : 0;
      hit_go = look && hit;
      evict  = look && !hit && mv[vict][s] && md[vict][s] && mreq_ready;
      miss   = look && !hit && !(mv[vict][s] && md[vict][s]) && mreq_ready && (mq.size() < DEPTH);
      pacc   = hit_go || miss;
      pfill  = (mq.size() > 0) && mresp_valid && !hit_go && !evict && !miss;
      paddr  = {(evict ? mt[vict][s] : tg), 3'(s), 2'b00};

      chk(req_accepted == pacc, "R2 R5 R8 accept", 64'(req_accepted), 64'(pacc));
      chk(mreq_valid == (evict || miss), "R4 R5 mem request valid", 64'(mreq_valid), 64'(evict || miss));
      if (evict || miss) begin
        chk(mreq_we == evict, "R4 R5 mem request kind", 64'(mreq_we), 64'(evict));
        chk(mreq_addr == paddr, "R3 R4 R5 mem request address", 64'(mreq_addr), 64'(paddr));
        if (evict) chk(mreq_line == ml[vict][s], "R4 write-back line", mreq_line, ml[vict][s]);
      end
      chk(mresp_ready == pfill, "R9 fill take", 64'(mresp_ready), 64'(pfill));
      chk(resp_valid == e_rv, "R2 R6 R7 response valid", 64'(resp_valid), 64'(e_rv));
      // R10: a double match would return a word from the wrong way here
      if (e_rv) chk(resp_data == e_rd, "R2 R6 R7 R10 response word", 64'(resp_data), 64'(e_rd));

      // memory side, driven by the observed handshakes
      if (mreq_valid && mreq_ready) begin
        if (mreq_we) mem[int'(mreq_addr >> 2)] = mreq_line;
        else rdq.push_back('{due: cyc + 2, line: get_line(int'(mreq_addr >> 2))});
      end
      if (mresp_ready && mresp_valid && rdq.size() > 0) void'(rdq.pop_front());

      // reference update
      n_rv = 0; n_rd = '0;
      if (hit_go) begin
        n_rv = 1;
        if (req_we) begin
          ml[hw][s][of*DW +: DW] = req_wdata;
          md[hw][s] = 1;
          n_rd = req_wdata;
        end else n_rd = ml[hw][s][of*DW +: DW];
      end
      if (look) mlru[s] = hit ? (hw == 0) : !mlru[s];
      if (evict) begin mv[vict][s] = 0; md[vict][s] = 0; end
      if (miss) mq.push_back('{way: vict, set: s, tag: tg, off: of, we: req_we, wd: req_wdata});
      if (pfill) begin
        mq_t e;
        logic [LW-1:0] l;
        e = mq.pop_front();
        l = mresp_line;
        if (e.we) l[e.off*DW +: DW] = e.wd;
        mv[e.way][e.set] = 1;
        md[e.way][e.set] = e.we;
        mt[e.way][e.set] = e.tag;
        ml[e.way][e.set] = l;
        n_rv = 1;
        n_rd = l[e.off*DW +: DW];
      end
      e_rv = n_rv; e_rd = n_rd;
      hold = req_valid && !req_accepted && (($urandom % 10) < 7);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule